// File: doc/BRIEF.md
# Serial Clock Baud Rate Generator

This block derives the serial bit clock of an SPI-style master from the system clock. Two encoded fields set the division. A 2-bit prescaler code picks a small odd-or-two divisor, and a 4-bit scaler code picks a divisor from 2 to 32768. A double-rate bit halves the combined division. The block also produces a one-cycle pulse on each leading (rising) edge and each trailing (falling) edge of the serial clock, so a shift register can act on those edges without watching the clock line itself.

The generator runs while `enable_i` is high. When the enable is low, or when any configuration input differs from the value seen in the previous cycle, the phase counter reloads and the serial clock goes back to its idle low level. After that restart, each period starts with its low phase. A typical use holds the configuration steady for a whole frame and raises the enable at the start of the frame.

Top module: `sck_baud_gen`

## Requirements
- R1: Prescaler code `pre_code_i` values 0, 1, 2 and 3 select prescale divisors 2, 3, 5 and 7.
- R2: Scaler code `scl_code_i` values 0 to 3 select divisors 2, 4, 6 and 8. A value c from 4 to 15 selects the divisor 2^c, so code 15 gives 32768.
- R3: With the configuration held and `enable_i` high, `sck_o` has a period of N = P*S/(1+D) system clocks. P is the prescale divisor, S is the scale divisor and D is `dbl_rate_i`.
- R4: With `dbl_rate_i` = 0, the high phase and the low phase of `sck_o` are each N/2 cycles long.
- R5: With `dbl_rate_i` = 1, the high phase is floor(N/2) cycles and the low phase is N - floor(N/2) cycles. When N is odd, the high phase is one cycle shorter than the low phase.
- R6: While `enable_i` is low, `sck_o`, `lead_o` and `trail_o` are 0. After the enable rises, `sck_o` stays low for one full low phase before its first rise. The restart cycle counts as the first cycle of that low phase.
- R7: If the configuration inputs change while the block is enabled, the clock edge that samples the change reloads the counter and drives `sck_o` low. Timing then restarts as in R6, using the new divisors.
- R8: `lead_o` is high for exactly one cycle: the first cycle in which `sck_o` is high. `trail_o` is high for exactly one cycle: the first low cycle that follows a high phase. A restart never produces either pulse.
- R9: While reset is active and right after it, `sck_o`, `lead_o` and `trail_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Runs the generator when high |
| pre_code_i | input | 2 | Prescaler code |
| scl_code_i | input | 4 | Scaler code |
| dbl_rate_i | input | 1 | Double-rate select |
| sck_o | output | 1 | Serial clock, idle low |
| lead_o | output | 1 | Pulse on the first high cycle of `sck_o` |
| trail_o | output | 1 | Pulse on the first low cycle after a high phase |

## Verification
The bench targets the smallest division, N = 2. A design with an off-by-one in its phase compare would stretch this case or hold the clock stuck. It also targets odd totals with the double-rate bit set, where a design that split the phases the wrong way would make the high phase the longer one. It changes the configuration mid-run without dropping the enable; a design that failed to reload would finish the old phase on the new divisors. It checks that no pulse appears on a restart, so a design that took a forced low level as a falling edge would give a spurious trailing pulse.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

    localparam int PRE_W   = 2;
    localparam int SCL_W   = 4;
    localparam int SCL_MAX = 1 << ((1 << SCL_W) - 1);
    localparam int PRE_MAX = 7;
    localparam int DIV_W   = $clog2(PRE_MAX * SCL_MAX + 1);

    typedef logic [DIV_W-1:0] div_t;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [SCL_W-1:0] scl;
        logic             dbl;
    } cfg_t;

    // Prescale divisor from its 2-bit code
    function automatic div_t pre_div(input logic [PRE_W-1:0] code);
        case (code)
            2'd0:    return div_t'(2);
            2'd1:    return div_t'(3);
            2'd2:    return div_t'(5);
            default: return div_t'(7);
        endcase
    endfunction

    // Scale divisor: linear steps for low codes, powers of two above
    function automatic div_t scl_div(input logic [SCL_W-1:0] code);
        if (code < SCL_W'(4))
            return div_t'((int'(code) + 1) * 2);
        else
            return div_t'(1) << code;
    endfunction

endpackage

// File: rtl/brg_div_decode.sv
module brg_div_decode
    import sbg_pkg::*;
(
    input  cfg_t cfg_i,
    output div_t hi_len_o,
    output div_t lo_len_o
);

    div_t prod;
    div_t total;

    always_comb begin
        prod     = pre_div(cfg_i.pre) * scl_div(cfg_i.scl);
        total    = cfg_i.dbl ? (prod >> 1) : prod;
        hi_len_o = total >> 1;
        lo_len_o = total - hi_len_o;
    end

    always_comb begin
        AST_PHASE_SPLIT: assert (hi_len_o >= div_t'(1) && lo_len_o >= hi_len_o
                                 && (lo_len_o - hi_len_o) <= div_t'(1)); // R5
    end

endmodule

// File: rtl/brg_phase.sv
module brg_phase
    import sbg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    input  div_t hi_len_i,
    input  div_t lo_len_i,
    output logic sck_o,
    output logic lead_o,
    output logic trail_o
);

    typedef struct packed {
        logic sck;
        logic lead;
        logic trail;
        div_t cnt;
    } ph_t;

    ph_t ph_d, ph_q;

    always_comb begin
        ph_d       = ph_q;
        ph_d.lead  = 1'b0;
        ph_d.trail = 1'b0;
        if (restart_i) begin
            ph_d.sck = 1'b0;
            ph_d.cnt = '0;
        end else if (!ph_q.sck && ph_q.cnt >= lo_len_i - div_t'(1)) begin
            ph_d.sck  = 1'b1;
            ph_d.lead = 1'b1;
            ph_d.cnt  = '0;
        end else if (ph_q.sck && ph_q.cnt >= hi_len_i - div_t'(1)) begin
            ph_d.sck   = 1'b0;
            ph_d.trail = 1'b1;
            ph_d.cnt   = '0;
        end else begin
            ph_d.cnt = ph_q.cnt + div_t'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ph_q <= '0;
        else         ph_q <= ph_d;
    end

    assign sck_o   = ph_q.sck;
    assign lead_o  = ph_q.lead;
    assign trail_o = ph_q.trail;

    AST_CNT_IN_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni || restart_i)
        ph_q.cnt < (ph_q.sck ? hi_len_i : lo_len_i)); // R3
    AST_LEAD_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lead_o |-> (sck_o && !$past(sck_o))); // R8
    AST_TRAIL_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trail_o |-> (!sck_o && $past(sck_o))); // R8
    AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(lead_o && trail_o)); // R8

endmodule

// File: rtl/sck_baud_gen.sv
module sck_baud_gen
    import sbg_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic [PRE_W-1:0] pre_code_i,
    input  logic [SCL_W-1:0] scl_code_i,
    input  logic             dbl_rate_i,
    output logic             sck_o,
    output logic             lead_o,
    output logic             trail_o
);

    cfg_t cfg_in;
    cfg_t cfg_d, cfg_q;
    logic restart;
    div_t hi_len, lo_len;

    assign cfg_in = '{pre: pre_code_i, scl: scl_code_i, dbl: dbl_rate_i};

    always_comb begin
        cfg_d   = cfg_in;
        restart = !enable_i || (cfg_in != cfg_q);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    brg_div_decode u_dec (
        .cfg_i    (cfg_in),
        .hi_len_o (hi_len),
        .lo_len_o (lo_len)
    );

    brg_phase u_ph (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .hi_len_i  (hi_len),
        .lo_len_i  (lo_len),
        .sck_o     (sck_o),
        .lead_o    (lead_o),
        .trail_o   (trail_o)
    );

    AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (!sck_o && !lead_o && !trail_o)); // R6
    AST_RESTART_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && cfg_in != cfg_q) |=> (!sck_o && !lead_o && !trail_o)); // R7

endmodule

// File: tb/sim_sck_baud_gen.sv
module sim_sck_baud_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] pre = '0;
    logic [3:0] scl = '0;
    logic       dbl = 1'b0;
    logic       sck, lead, trail;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sck_baud_gen u0 (
        .clk_i (clk), .rst_ni (rst_n), .enable_i (en),
        .pre_code_i (pre), .scl_code_i (scl), .dbl_rate_i (dbl),
        .sck_o (sck), .lead_o (lead), .trail_o (trail)
    );

    function automatic int exp_pre(input int c);
        case (c)
            0: return 2;
            1: return 3;
            2: return 5;
            default: return 7;
        endcase
    endfunction

    function automatic int exp_scl(input int c);
        case (c)
            0: return 2;      1: return 4;      2: return 6;      3: return 8;
            4: return 16;     5: return 32;     6: return 64;     7: return 128;
            8: return 256;    9: return 512;    10: return 1024;  11: return 2048;
            12: return 4096;  13: return 8192;  14: return 16384; default: return 32768;
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Restart with new config (by disable or by config change), then follow ncyc cycles
    task automatic run(input int p, input int s, input int d, input int ncyc, input bit use_dis);
        int n, hi, lo;
        n  = (exp_pre(p) * exp_scl(s)) / (1 + d);
        hi = n / 2;
        lo = n - hi;
        @(negedge clk);
        if (use_dis) begin
            en = 1'b0;
            pre = 2'(p); scl = 4'(s); dbl = 1'(d);
            @(negedge clk);
            en = 1'b1;
        end else begin
            pre = 2'(p); scl = 4'(s); dbl = 1'(d);
            @(negedge clk);
        end
        for (int j = 0; j < ncyc; j++) begin
            int pos;
            if (j > 0) @(negedge clk);
            pos = j % n;
            check(use_dis ? "R1 R2 R3 R4 R5 R6 sck" : "R1 R2 R3 R4 R5 R7 sck", sck, pos >= lo);
            check("R8 lead", lead, (j > 0) && (pos == lo));
            check("R8 trail", trail, (j > 0) && (pos == 0));
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R9 sck in reset", sck, 1'b0);
        check("R9 lead in reset", lead, 1'b0);
        check("R9 trail in reset", trail, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 sck after reset", sck, 1'b0);
        // R6 idle while disabled, config set
        pre = 2'd0; scl = 4'd0; dbl = 1'b0;
        repeat (6) begin
            @(negedge clk);
            check("R6 idle sck", sck, 1'b0);
            check("R6 idle lead", lead, 1'b0);
            check("R6 idle trail", trail, 1'b0);
        end
        // directed corners
        run(0, 0, 0, 12, 1'b1);     // N=4
        run(0, 0, 1, 10, 1'b1);     // N=2 smallest
        run(1, 0, 1, 12, 1'b1);     // N=3 odd, R5
        run(3, 2, 1, 50, 1'b1);     // N=21 odd, R5
        run(1, 3, 0, 30, 1'b0);     // R7 change mid-run
        run(2, 1, 1, 30, 1'b0);     // R7 N=10
        run(3, 11, 1, 2 * 7168 + 4, 1'b1); // large division
        // random mix
        for (int k = 0; k < 30; k++) begin
            int p, s, d, n;
            bit ud;
            p  = int'($urandom_range(3, 0));
            s  = int'($urandom_range(7, 0));
            d  = int'($urandom_range(1, 0));
            ud = 1'($urandom_range(1, 0));
            if (p == int'(pre) && s == int'(scl) && d == int'(dbl)) ud = 1'b1;
            n  = (exp_pre(p) * exp_scl(s)) / (1 + d);
            run(p, s, d, 2 * n + 3, ud);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule